// File: doc/BRIEF.md
# Bidirectional Latched Bus Transceiver

This block moves a data word between two ports, A and B, in either direction without inverting it. Each direction owns a bank of level-sensitive latches and three active-low controls. The direction enable gates both the loading of that bank and the driving of its destination port. The latch enable selects between a transparent latch and a held latch. The output enable gates the destination port's drivers. A word from port A is loaded into the A-to-B bank and presented on port B. The B-to-A direction works the same way with its own bank and controls.

Each port is split into an input vector, an output vector and a per-bit output-enable vector, so the block stays synthesizable. An enclosing wrapper can merge the three into a tri-state pin. The latches have no reset. The system fills them by running a transparent phase before it relies on the stored contents. Both directions may hold data and drive their ports at the same time. The two banks are fully independent, so each port then shows the word held for it.

Top module: `latched_xcvr`

## Requirements
- R1: Both data paths are WIDTH bits wide (default 8) and pass every bit unchanged, with no inversion. All-zero, all-one and alternating patterns arrive intact.
- R2: While the A-to-B direction enable is high, port B's output-enable vector is all zero and its output vector is all zero, whatever the other two controls are. The A-to-B bank keeps its contents through any changes on port A during that time.
- R3: With the A-to-B direction enable low and the A-to-B latch enable low, the bank is transparent. With the output enable also low, port B's output equals port A's input in the same cycle.
- R4: A low-to-high step of the A-to-B latch enable, taken while the direction enable is low, freezes the bank at the port A word present before the step. Later changes on port A do not reach port B.
- R5: Port B is driven only when the A-to-B direction enable and the A-to-B output enable are both low. Port B's output-enable bits are then all one. Otherwise they are all zero, and the output vector is zero.
- R6: With the A-to-B direction enable low, the latch enable high and the output enable low, port B shows the word held in the A-to-B bank.
- R7: The B-to-A direction follows R2 to R6 with its own three controls, taking data from port B and driving port A.
- R8: When both directions hold data and both drive at the same time, port B shows the word held for A-to-B and port A shows the word held for B-to-A. Changes on either input port have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH | Word seen on port A, loaded into the A-to-B bank |
| a_out | output | WIDTH | Word driven onto port A by the B-to-A direction |
| a_oe | output | WIDTH | Per-bit drive enable for port A, active high |
| b_in | input | WIDTH | Word seen on port B, loaded into the B-to-A bank |
| b_out | output | WIDTH | Word driven onto port B by the A-to-B direction |
| b_oe | output | WIDTH | Per-bit drive enable for port B, active high |
| ab_en_n | input | 1 | A-to-B direction enable, active low |
| ab_le_n | input | 1 | A-to-B latch enable, active low (low is transparent) |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ba_en_n | input | 1 | B-to-A direction enable, active low |
| ba_le_n | input | 1 | B-to-A latch enable, active low (low is transparent) |
| ba_oe_n | input | 1 | B-to-A output enable, active low |

## Verification
The block has no clock, so every output settles within the cycle in which a control or data input changes. The bench applies inputs just after the rising edge and samples half a period later, on the falling edge. A held word depends on earlier cycles. The reference model therefore updates its stored copy only on falling edges where that direction is enabled and transparent, and it never moves a latch-enable step and a data change into the same cycle. Each freeze test raises the latch enable one cycle before it changes the input word. In this way the expected value of every sample is fixed without any race at the edge.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef struct packed {
    logic en_n;
    logic le_n;
    logic oe_n;
  } dir_ctrl_t;

  function automatic logic latch_open(input dir_ctrl_t c);
    return (!c.en_n) && (!c.le_n);
  endfunction

  function automatic logic drive_on(input dir_ctrl_t c);
    return (!c.en_n) && (!c.oe_n);
  endfunction

endpackage

// File: rtl/xcvr_latch_bank.sv
module xcvr_latch_bank #(
  parameter int WIDTH = 8
) (
  input  logic             open_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic q_bit;
    always_latch begin
      if (open_i) q_bit = d_i[i];
    end
    assign q_o[i] = q_bit;
  end

endmodule

// File: rtl/xcvr_drive_stage.sv
module xcvr_drive_stage #(
  parameter int WIDTH = 8
) (
  input  logic             on_i,
  input  logic [WIDTH-1:0] q_i,
  output logic [WIDTH-1:0] dout_o,
  output logic [WIDTH-1:0] oe_o
);

  always_comb begin
    oe_o   = {WIDTH{on_i}};
    dout_o = on_i ? q_i : '0;
  end

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  dir_ctrl_t        ctrl_i,
  input  logic [WIDTH-1:0] src_i,
  output logic [WIDTH-1:0] dst_out_o,
  output logic [WIDTH-1:0] dst_oe_o,
  output logic             open_o,
  output logic             drive_o,
  output logic [WIDTH-1:0] held_o
);

  assign open_o  = latch_open(ctrl_i);
  assign drive_o = drive_on(ctrl_i);

  xcvr_latch_bank #(.WIDTH(WIDTH)) u_bank (
    .open_i (open_o),
    .d_i    (src_i),
    .q_o    (held_o)
  );

  xcvr_drive_stage #(.WIDTH(WIDTH)) u_drive (
    .on_i   (drive_o),
    .q_i    (held_o),
    .dout_o (dst_out_o),
    .oe_o   (dst_oe_o)
  );

endmodule

// File: rtl/latched_xcvr.sv
module latched_xcvr
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic [WIDTH-1:0] a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic [WIDTH-1:0] b_oe,
  input  logic             ab_en_n,
  input  logic             ab_le_n,
  input  logic             ab_oe_n,
  input  logic             ba_en_n,
  input  logic             ba_le_n,
  input  logic             ba_oe_n
);

  dir_ctrl_t        ab_ctrl, ba_ctrl;
  logic             ab_open, ab_drive, ba_open, ba_drive;
  logic [WIDTH-1:0] ab_held, ba_held;

  assign ab_ctrl = '{en_n: ab_en_n, le_n: ab_le_n, oe_n: ab_oe_n};
  assign ba_ctrl = '{en_n: ba_en_n, le_n: ba_le_n, oe_n: ba_oe_n};

  xcvr_lane #(.WIDTH(WIDTH)) u_ab (
    .ctrl_i    (ab_ctrl),
    .src_i     (a_in),
    .dst_out_o (b_out),
    .dst_oe_o  (b_oe),
    .open_o    (ab_open),
    .drive_o   (ab_drive),
    .held_o    (ab_held)
  );

  xcvr_lane #(.WIDTH(WIDTH)) u_ba (
    .ctrl_i    (ba_ctrl),
    .src_i     (b_in),
    .dst_out_o (a_out),
    .dst_oe_o  (a_oe),
    .open_o    (ba_open),
    .drive_o   (ba_drive),
    .held_o    (ba_held)
  );

endmodule

// File: rtl/latched_xcvr_chk.sv
module latched_xcvr_chk #(
  parameter int WIDTH = 8
) (
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] a_out,
  input logic [WIDTH-1:0] a_oe,
  input logic [WIDTH-1:0] b_in,
  input logic [WIDTH-1:0] b_out,
  input logic [WIDTH-1:0] b_oe,
  input logic             ab_en_n,
  input logic             ab_le_n,
  input logic             ab_oe_n,
  input logic             ba_en_n,
  input logic             ba_le_n,
  input logic             ba_oe_n,
  input logic             ab_open,
  input logic             ba_open,
  input logic [WIDTH-1:0] ab_held,
  input logic [WIDTH-1:0] ba_held
);

  always_comb begin
    // R2: a disabled A-to-B direction never drives port B
    if (ab_en_n) a_r2_b_quiet: assert (b_oe == '0);
    // R5: port B drive needs both enables low; enable bits move together
    if (b_oe != '0) a_r5_b_gate: assert (!ab_en_n && !ab_oe_n && (b_oe == '1));
    // R3: an open bank follows port A
    if (ab_open) a_r3_follow: assert (ab_held == a_in);
    // R6: a driven port B carries the bank contents
    if (b_oe != '0) a_r6_b_shows_held: assert (b_out == ab_held);
    // R7: mirror direction gating and transparency
    if (ba_en_n) a_r7_a_quiet: assert (a_oe == '0);
    if (ba_open) a_r7_follow: assert (ba_held == b_in);
    if (a_oe != '0) a_r7_a_shows_held: assert ((a_out == ba_held) && !ba_oe_n);
  end

endmodule

bind latched_xcvr latched_xcvr_chk #(.WIDTH(WIDTH)) u_chk (
  .a_in    (a_in),
  .a_out   (a_out),
  .a_oe    (a_oe),
  .b_in    (b_in),
  .b_out   (b_out),
  .b_oe    (b_oe),
  .ab_en_n (ab_en_n),
  .ab_le_n (ab_le_n),
  .ab_oe_n (ab_oe_n),
  .ba_en_n (ba_en_n),
  .ba_le_n (ba_le_n),
  .ba_oe_n (ba_oe_n),
  .ab_open (ab_open),
  .ba_open (ba_open),
  .ab_held (ab_held),
  .ba_held (ba_held)
);

// File: tb/tb_latched_xcvr.sv
`timescale 1ns/1ps
module tb_latched_xcvr;
  localparam int W = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic [W-1:0] a_drv = '0, b_drv = '0;
  logic a_drv_en = 1'b0, b_drv_en = 1'b0;
  logic ab_en_n = 1'b1, ab_le_n = 1'b1, ab_oe_n = 1'b1;
  logic ba_en_n = 1'b1, ba_le_n = 1'b1, ba_oe_n = 1'b1;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  latched_xcvr #(.WIDTH(W)) dut (
    .a_in(a_drv), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_drv), .b_out(b_out), .b_oe(b_oe),
    .ab_en_n(ab_en_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
    .ba_en_n(ba_en_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: stored words, updated only when a direction is enabled and transparent
  logic [W-1:0] ref_ab, ref_ba;
  bit ref_ab_ok = 0, ref_ba_ok = 0;

  function automatic string tag_of(input logic en_n, le_n, oe_n, input string side);
    if (side == "BA") return "R7";
    if (en_n) return "R2";
    if (oe_n) return "R5";
    if (!le_n) return "R3";
    return "R6";
  endfunction

  always @(negedge clk) begin
    bit ab_on, ba_on;
    string t_ab, t_ba;
    if (!ab_en_n && !ab_le_n) begin ref_ab = a_drv; ref_ab_ok = 1; end
    if (!ba_en_n && !ba_le_n) begin ref_ba = b_drv; ref_ba_ok = 1; end
    ab_on = !ab_en_n && !ab_oe_n;
    ba_on = !ba_en_n && !ba_oe_n;
    t_ab = (ab_on && ba_on) ? "R8" : tag_of(ab_en_n, ab_le_n, ab_oe_n, "AB");
    t_ba = (ab_on && ba_on) ? "R8" : tag_of(ba_en_n, ba_le_n, ba_oe_n, "BA");
    chk({t_ab, " b_oe"}, b_oe, ab_on ? '1 : '0);
    if (!ab_on) chk({t_ab, " b_out"}, b_out, '0);
    else if (ref_ab_ok) chk({t_ab, " b_out"}, b_out, ref_ab);
    chk({t_ba, " a_oe"}, a_oe, ba_on ? '1 : '0);
    if (!ba_on) chk({t_ba, " a_out"}, a_out, '0);
    else if (ref_ba_ok) chk({t_ba, " a_out"}, a_out, ref_ba);
    // R5 contention: a port driven by the block while the bench also drives it
    chk("R5 contention on B", {7'd0, (b_oe != '0) && b_drv_en}, '0);
    chk("R7 contention on A", {7'd0, (a_oe != '0) && a_drv_en}, '0);
  end

  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk);
    #0.5;
  endtask

  task automatic look(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    @(negedge clk);
    #0.5;
    chk(tag, act, exp);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1 actual=timeout expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    // Reset phase: everything disabled
    tick(3);
    look("R2 reset b_oe", b_oe, '0);
    look("R7 reset a_oe", a_oe, '0);
    rst_n = 1'b1;

    // R1 and R3: transparent A-to-B with several patterns
    a_drv_en = 1; tick();
    ab_en_n = 0; ab_le_n = 0; ab_oe_n = 0;
    foreach (a_drv[i]) begin end
    a_drv = 8'h00; tick(); look("R1 zeros", b_out, 8'h00);
    a_drv = 8'hFF; tick(); look("R1 ones", b_out, 8'hFF);
    a_drv = 8'hA5; tick(); look("R3 follow A5", b_out, 8'hA5);
    a_drv = 8'h5A; tick(); look("R1 alternating", b_out, 8'h5A);

    // R4: freeze on latch-enable rise, then change A
    ab_le_n = 1; tick(); look("R4 frozen", b_out, 8'h5A);
    a_drv = 8'h3C; tick(); look("R4 ignore A", b_out, 8'h5A);
    a_drv = 8'hC3; tick(); look("R4 ignore A again", b_out, 8'h5A);

    // R5 output gating, R6 stored word reappears
    ab_oe_n = 1; tick(); look("R5 off oe", b_oe, '0);
    look("R5 off data", b_out, '0);
    ab_oe_n = 0; tick(); look("R6 stored", b_out, 8'h5A);

    // R2: direction disabled holds bank against A changes even with latch enable low
    ab_en_n = 1; tick(); look("R2 oe off", b_oe, '0);
    ab_le_n = 0; a_drv = 8'h11; tick(); look("R2 data off", b_out, '0);
    a_drv = 8'h22; tick();
    ab_le_n = 1; tick();
    ab_en_n = 0; tick(); look("R2 bank held", b_out, 8'h5A);

    // R7: mirror direction; free port B first
    ab_oe_n = 1; a_drv_en = 0; tick();
    b_drv_en = 1; ba_en_n = 0; ba_le_n = 0; ba_oe_n = 0;
    b_drv = 8'h96; tick(); look("R7 follow", a_out, 8'h96);
    b_drv = 8'h0F; tick(); look("R7 follow 0F", a_out, 8'h0F);
    ba_le_n = 1; tick();
    b_drv = 8'hE1; tick(); look("R7 frozen", a_out, 8'h0F);
    ba_oe_n = 1; tick(); look("R7 off", a_oe, '0);
    ba_en_n = 1; ba_le_n = 0; b_drv = 8'h44; tick();
    ba_le_n = 1; tick();
    ba_en_n = 0; ba_oe_n = 0; tick(); look("R7 bank held", a_out, 8'h0F);

    // R8: both directions hold and drive at once
    b_drv_en = 0; tick();
    ab_oe_n = 0; tick();
    look("R8 B side", b_out, 8'h5A);
    look("R8 A side", a_out, 8'h0F);
    a_drv = 8'h77; b_drv = 8'h88; tick();
    look("R8 B unchanged", b_out, 8'h5A);
    look("R8 A unchanged", a_out, 8'h0F);

    ab_en_n = 1; ba_en_n = 1; tick(2);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule